// File: doc/BRIEF.md
# Embedded Word Clock Deserializer

This block receives a serial data line together with the bit clock that travels beside it. Both inputs arrive already sampled into the system clock domain, and the system clock runs `BIT_CYC` times faster than the bit rate. In normal bit slots the forwarded clock is low for the first half of the slot and high for the second half, and each bit is taken on the rising edge. A word ends in a boundary window. In that window the clock rises for one extra bit and then stays high for three bit times instead of pulsing low. The bit that lies one bit time after that rise is taken as the second boundary bit. The falling edge that closes the long high period marks the end of the word.

At that falling edge the 26 most recent bits are taken as one frame. The two boundary bits are checked and then dropped, and the 24 payload bits go to the parallel port. About six bit times later an active-low word strobe opens, and it stays low for thirteen bit times. A direction select chooses between this receive role and an idle role. In the idle role the parallel port is released (output enable low) and the serial input has no effect.

Top module: `ewc_deser`

## Requirements
- R1: A boundary end is a falling edge of `ser_clk` that follows a high period of at least 2·BIT_CYC system clocks. Shorter high periods (half a bit time in normal slots) are ordinary bits.
- R2: Bits are taken on each rising edge of `ser_clk`, and also BIT_CYC clocks into a long high period. The first bit of a word appears on `par_data[0]` and the 24th on `par_data[23]`. The two boundary bits never reach `par_data`.
- R3: `par_data` takes the new word on the clock edge that samples the boundary-ending fall. It holds that value until the next accepted word.
- R4: `word_stb_n` falls 6·BIT_CYC clocks after that edge and stays low for exactly 13·BIT_CYC clocks.
- R5: When no boundary occurs, `word_stb_n` stays high and `par_data` stays unchanged, however many bits arrive.
- R6: After reset, `par_data` is all zero, `word_stb_n` is 1 and `frame_err` is 0.
- R7: `par_oe` equals `dir_rx`. While `dir_rx` is 0, serial traffic and boundaries change neither `par_data` nor `word_stb_n`.
- R8: Filler bits sent before a word are ignored. The frame is always the last 26 bits before the boundary end.
- R9: When fewer than 26 bits (payload plus boundary bits) have arrived since the previous boundary, the word is discarded. No strobe is produced and `par_data` is unchanged.
- R10: The frame is well formed when the first boundary bit is the inverse of bit 24 and the second boundary bit equals bit 24. A badly formed frame sets `frame_err`, which stays 1 until reset. The word is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_rx | input | 1 | 1 selects the receive role |
| ser_clk | input | 1 | Sampled forwarded bit clock |
| ser_data | input | 1 | Sampled serial data |
| par_data | output | 24 | Recovered word, bit 1 on index 0 |
| par_oe | output | 1 | Output enable for the parallel port |
| word_stb_n | output | 1 | Active-low word strobe |
| frame_err | output | 1 | Sticky malformed-boundary flag |

## Verification
The hardest state to reach from the ports is a long clock-high window that ends a word the block must reject. One such case has too few bits since the last boundary. The other arrives while the receive role is off. In both cases the only evidence is that nothing happens. The stimulus therefore sends a short burst followed by a proper three-bit-time high window. It also sends a complete, well-formed frame while the direction select is low. In each case the bench counts strobe falls over a window longer than a full strobe cycle and compares the parallel word before and after. Filler bits placed ahead of several table words check that framing always follows the boundary, and the last table entry deliberately corrupts the boundary bits.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

    typedef enum logic [1:0] {
        STB_IDLE,
        STB_WAIT,
        STB_LOW
    } stb_state_e;

endpackage

// File: rtl/ewc_edge.sv
module ewc_edge #(
    parameter int BIT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    output logic shift_en,
    output logic shift_bit,
    output logic bnd_end
);
    localparam int HI_MAX = 2 * BIT_CYC;
    localparam int HW     = $clog2(HI_MAX + 1);

    typedef struct packed {
        logic          ck;
        logic [HW-1:0] hi;
    } edge_regs_t;

    edge_regs_t r_d, r_q;
    logic       rise, held, mid;

    always_comb begin
        r_d       = r_q;
        r_d.ck    = ser_clk;
        rise      = ser_clk & ~r_q.ck;
        held      = ser_clk & r_q.ck;
        mid       = held & (r_q.hi == HW'(BIT_CYC - 1));
        if (held) begin
            if (r_q.hi != HW'(HI_MAX)) r_d.hi = r_q.hi + 1'b1;
        end else begin
            r_d.hi = '0;
        end
        shift_en  = rise | mid;
        shift_bit = ser_data;
        bnd_end   = ~ser_clk & r_q.ck & (r_q.hi == HW'(HI_MAX));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R1
    boundary_long_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_end |-> ($past(ser_clk, 2) && $past(ser_clk, 3)));

endmodule

// File: rtl/ewc_framer.sv
module ewc_framer #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              bnd_end,
    output logic              word_load,
    output logic [WORD_W-1:0] word_q,
    output logic              ferr_q
);
    localparam int FRAME_W = WORD_W + 2;
    localparam int CW      = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CW-1:0]      cnt;
        logic [WORD_W-1:0]  word;
        logic               ferr;
    } frm_regs_t;

    frm_regs_t r_d, r_q;
    logic      full, bad;

    always_comb begin
        r_d       = r_q;
        full      = (r_q.cnt == CW'(FRAME_W));
        bad       = (r_q.sr[1] == r_q.sr[2]) | (r_q.sr[0] != r_q.sr[2]);
        word_load = rx_en & bnd_end & full;
        if (!rx_en) begin
            r_d.cnt = '0;
        end else if (bnd_end) begin
            r_d.cnt = '0;
        end else if (shift_en) begin
            r_d.sr = {r_q.sr[FRAME_W-2:0], shift_bit};
            if (!full) r_d.cnt = r_q.cnt + 1'b1;
        end
        if (word_load) begin
            for (int i = 0; i < WORD_W; i++) r_d.word[i] = r_q.sr[FRAME_W-1-i];
            if (bad) r_d.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign word_q = r_q.word;
    assign ferr_q = r_q.ferr;

    // R10
    ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ferr_q));

endmodule

// File: rtl/ewc_strobe.sv
module ewc_strobe
    import ewc_pkg::*;
#(
    parameter int BIT_CYC  = 8,
    parameter int DLY_BITS = 6,
    parameter int LOW_BITS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic stb_n
);
    localparam int DLY_CYC = DLY_BITS * BIT_CYC;
    localparam int LOW_CYC = LOW_BITS * BIT_CYC;
    localparam int MAX_CYC = (DLY_CYC > LOW_CYC) ? DLY_CYC : LOW_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        stb_state_e    st;
        logic [CW-1:0] cnt;
    } stb_regs_t;

    stb_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.cnt = r_q.cnt + 1'b1;
        if (start) begin
            r_d.st  = STB_WAIT;
            r_d.cnt = '0;
        end else begin
            case (r_q.st)
                STB_WAIT: if (r_q.cnt == CW'(DLY_CYC - 1)) begin
                    r_d.st  = STB_LOW;
                    r_d.cnt = '0;
                end
                STB_LOW: if (r_q.cnt == CW'(LOW_CYC - 1)) begin
                    r_d.st  = STB_IDLE;
                    r_d.cnt = '0;
                end
                default: r_d.cnt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: STB_IDLE, cnt: '0};
        else        r_q <= r_d;
    end

    assign stb_n = (r_q.st != STB_LOW);

    // R4
    strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> stb_n);

endmodule

// File: rtl/ewc_deser.sv
module ewc_deser #(
    parameter int BIT_CYC  = 8,
    parameter int WORD_W   = 24,
    parameter int DLY_BITS = 6,
    parameter int LOW_BITS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_rx,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic [WORD_W-1:0] par_data,
    output logic              par_oe,
    output logic              word_stb_n,
    output logic              frame_err
);
    logic shift_en, shift_bit, bnd_end, word_load;

    ewc_edge #(.BIT_CYC(BIT_CYC)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .bnd_end   (bnd_end)
    );

    ewc_framer #(.WORD_W(WORD_W)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (dir_rx),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .bnd_end   (bnd_end),
        .word_load (word_load),
        .word_q    (par_data),
        .ferr_q    (frame_err)
    );

    ewc_strobe #(.BIT_CYC(BIT_CYC), .DLY_BITS(DLY_BITS), .LOW_BITS(LOW_BITS)) u_stb (
        .clk   (clk),
        .rst_n (rst_n),
        .start (word_load),
        .stb_n (word_stb_n)
    );

    assign par_oe = dir_rx;

    // R7
    dir_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_data != $past(par_data)) |-> $past(dir_rx));

    // R3
    data_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_stb_n && $past(!word_stb_n)) |-> $stable(par_data));

endmodule

// File: tb/sim_ewc_deser.sv
module sim_ewc_deser;
    localparam int BIT_CYC = 8;
    localparam int HALF    = BIT_CYC / 2;
    localparam int DLY     = 6 * BIT_CYC;
    localparam int LOWC    = 13 * BIT_CYC;
    localparam int NVEC    = 5;
    // [23:0] word, [27:24] filler bits, [28] corrupt boundary
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00A5C30F, 32'h03000001, 32'h00800000, 32'h075A5A5A, 32'h11FFFFFF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_rx = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [23:0] par_data;
    logic        par_oe, word_stb_n, frame_err;

    int n_chk = 0;
    int n_bad = 0;
    int falls = 0;
    logic stb_prev = 1'b1;
    logic done = 1'b0;

    always #10 clk = ~clk;

    ewc_deser u0 (
        .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .ser_clk(ser_clk),
        .ser_data(ser_data), .par_data(par_data), .par_oe(par_oe),
        .word_stb_n(word_stb_n), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (stb_prev && !word_stb_n) falls++;
        stb_prev = word_stb_n;
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b0;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_bnd(input logic b25, input logic b26);
        @(negedge clk);
        ser_data = b25;
        ser_clk  = 1'b0;
        repeat (HALF) @(negedge clk);
        ser_clk = 1'b1;
        repeat (HALF) @(negedge clk);
        ser_data = b26;
        repeat (3 * BIT_CYC - HALF) @(negedge clk);
        ser_clk  = 1'b0;
        ser_data = 1'b0;
    endtask

    task automatic send_word(input logic [23:0] w, input logic corrupt);
        for (int i = 0; i < 24; i++) send_bit(w[i]);
        if (corrupt) send_bnd(w[23], w[23]);
        else         send_bnd(~w[23], w[23]);
    endtask

    task automatic check_strobe(input string req);
        repeat (DLY - 1) @(posedge clk);
        #1 check(word_stb_n == 1'b1, req, word_stb_n, 1);
        @(posedge clk);
        #1 check(word_stb_n == 1'b0, req, word_stb_n, 0);
        repeat (LOWC - 1) @(posedge clk);
        #1 check(word_stb_n == 1'b0, req, word_stb_n, 0);
        @(posedge clk);
        #1 check(word_stb_n == 1'b1, req, word_stb_n, 1);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] hold;
        int f0;
        repeat (3) @(negedge clk);
        // R6 reset state
        check(par_data == 24'h0, "R6", par_data, 0);
        check(word_stb_n == 1'b1, "R6", word_stb_n, 1);
        check(frame_err == 1'b0, "R6", frame_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(par_oe == 1'b1, "R7", par_oe, 1);

        // R2 R3 R4 R8 R10: table walk
        for (int v = 0; v < NVEC; v++) begin
            for (int f = 0; f < int'(VEC[v][27:24]); f++) send_bit(f[0]);
            send_word(VEC[v][23:0], VEC[v][28]);
            @(posedge clk);
            #1 check(par_data == VEC[v][23:0], "R2/R3/R8", par_data, VEC[v][23:0]);
            check(frame_err == VEC[v][28], "R10", frame_err, VEC[v][28]);
            check_strobe("R4");
        end

        // R9 short word discarded, R10 flag still set
        hold = par_data;
        f0 = falls;
        for (int i = 0; i < 10; i++) send_bit(1'b0);
        send_bnd(1'b1, 1'b0);
        repeat (DLY + LOWC + 20) @(posedge clk);
        #1 check(falls == f0, "R9", falls, f0);
        check(par_data == hold, "R9", par_data, hold);
        check(frame_err == 1'b1, "R10 sticky", frame_err, 1);

        // R5 no boundary at all
        f0 = falls;
        for (int i = 0; i < 40; i++) send_bit(i[1]);
        repeat (DLY + LOWC + 20) @(posedge clk);
        #1 check(falls == f0, "R5", falls, f0);
        check(par_data == hold, "R5", par_data, hold);

        // R7 direction off
        @(negedge clk);
        dir_rx = 1'b0;
        #1 check(par_oe == 1'b0, "R7", par_oe, 0);
        f0 = falls;
        send_word(24'h123456, 1'b0);
        repeat (DLY + LOWC + 20) @(posedge clk);
        #1 check(falls == f0, "R7", falls, f0);
        check(par_data == hold, "R7", par_data, hold);
        @(negedge clk);
        dir_rx = 1'b1;
        send_word(24'h6C3E91, 1'b0);
        @(posedge clk);
        #1 check(par_data == 24'h6C3E91, "R7 resume", par_data, 24'h6C3E91);
        check_strobe("R4 resume");

        // R6 reset clears flag and data
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(par_data == 24'h0, "R6", par_data, 0);
        check(frame_err == 1'b0, "R6", frame_err, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule